// File: doc/BRIEF.md
# Codec Line-Output Power Sequencer

This block is a hardware controller that powers a mono audio codec's line output up and down without audible clicks. It has a fixed, ordered script of register writes for each direction, held in a small script table. It issues each write as an address/data pair on a valid/ready port toward a serial control-bus master. Between the write that switches the analog stages and the write that releases the output's power-save clamp, it waits a settling time. That time is counted in pulses of a prescaled timing tick.

A start request runs the power-up script from the idle state. When that script completes, the output is live. A stop request then runs the power-down script, which returns the block to idle. A stop request that arrives while power-up is still running is remembered and served as soon as power-up ends. The settling wait is `WAIT_TICKS` ticks. Its default is derived from `TICK_US` so that it exceeds 300 ms.

The states are IDLE, ISSUE (a write is offered), SETTLE (timed wait) and LIVE (output active). The transitions are:
- IDLE→ISSUE on start.
- ISSUE→ISSUE on the handshake of an ordinary step.
- ISSUE→SETTLE on the handshake of a step that needs settling.
- SETTLE→ISSUE when the wait expires.
- ISSUE→LIVE on the handshake of the last power-up step.
- ISSUE→IDLE on the handshake of the last power-down step.
- LIVE→ISSUE on a direct or latched stop.

Top module: `lineout_seq`

## Requirements
- R1: After reset the block is in IDLE. `wr_valid_o`, `busy_o`, `active_o` and `done_o` are low, and no write is offered until a start request.
- R2: Power-up writes, in this order, (address=data hex): 05=02, 02=10, 03=02, 07=00, 0A=91, 03=42, 00=CC, 03=02.
- R3: While `wr_valid_o` is high and `wr_ready_i` is low, valid, address and data hold steady. The next step begins only after a cycle with both valid and ready high.
- R4: In power-up, at least `WAIT_TICKS` ticks are counted after the 00=CC handshake before the 03=02 write is offered.
- R5: `active_o` rises in the cycle after the last power-up handshake. `done_o` is high for exactly that one cycle.
- R6: A stop request while LIVE starts power-down on the next clock. `active_o` is low from the cycle in which the first power-down write is offered.
- R7: Power-down writes, in order, 03=42, 00=40, 02=00, 03=02. At least `WAIT_TICKS` ticks pass after the 00=40 handshake before the final 03=02 write is offered.
- R8: Every write to register 00 sets the DAC (bit 2), line-output (bit 3) and filter (bit 7) power bits to the same value. In register 03, bit 6 is the output power-save flag and bit 1 the filter-to-DAC path select.
- R9: A stop request during power-up is held and served. The first power-down write is offered two cycles after the last power-up handshake, with no further request.
- R10: A start request while busy or LIVE is ignored, and so is a stop request while IDLE.
- R11: After the last power-down handshake, `done_o` pulses for one cycle, and `busy_o` and `active_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled timing tick, one-cycle pulse |
| start_i | input | 1 | Request to bring the line output up |
| stop_i | input | 1 | Request to take the line output down |
| wr_valid_o | output | 1 | Register write offered |
| wr_addr_o | output | 8 | Codec register address |
| wr_data_o | output | 8 | Codec register value |
| wr_ready_i | input | 1 | Control-bus master accepts the write |
| busy_o | output | 1 | A script is running |
| active_o | output | 1 | Line output is live |
| done_o | output | 1 | One-cycle pulse at the end of either script |

## Verification
Two events can fall in the same cycle: a stop request and the final handshake of power-up. The latched-stop path must then turn LIVE straight into power-down without losing the request. The bench provokes this by pulsing stop early in power-up and then completing the script. It judges the result at the ports: `active_o` and `done_o` must be high for one cycle, followed by the 03=42 write with `active_o` low. A tick can also coincide with the handshake that starts a wait. The bench counts ticks from that handshake edge onward and requires at least `WAIT_TICKS` before the release write appears.

// File: rtl/lineout_seq_pkg.sv
package lineout_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_SETTLE,
        ST_LIVE
    } seq_state_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic       settle_after;
        logic       final_step;
    } script_entry_t;

    localparam int STEP_W   = 4;
    localparam int UP_FIRST = 0;
    localparam int DN_FIRST = 8;

    // register addresses
    localparam logic [7:0] RG_POWER = 8'h00;
    localparam logic [7:0] RG_ROUTE = 8'h02;
    localparam logic [7:0] RG_MODE  = 8'h03;
    localparam logic [7:0] RG_RATE  = 8'h05;
    localparam logic [7:0] RG_LEVEL = 8'h07;
    localparam logic [7:0] RG_VOL   = 8'h0A;

    // bit positions decoded by the codec
    localparam int MODE_PSAVE_BIT = 6;
    localparam int MODE_FDAC_BIT  = 1;
    localparam int ROUTE_LINE_BIT = 4;
    localparam int PWR_DAC_BIT    = 2;
    localparam int PWR_LINE_BIT   = 3;
    localparam int PWR_FILT_BIT   = 7;
    localparam logic [7:0] PWR_OTHER = 8'h40;

    function automatic logic [7:0] power_word(input logic on);
        logic [7:0] w;
        w = PWR_OTHER;
        w[PWR_DAC_BIT]  = on;
        w[PWR_LINE_BIT] = on;
        w[PWR_FILT_BIT] = on;
        return w;
    endfunction

    function automatic logic [7:0] mode_word(input logic psave);
        logic [7:0] w;
        w = 8'h00;
        w[MODE_FDAC_BIT]  = 1'b1;
        w[MODE_PSAVE_BIT] = psave;
        return w;
    endfunction

endpackage

// File: rtl/lo_script_rom.sv
module lo_script_rom
    import lineout_seq_pkg::*;
#(
    parameter logic [7:0] RATE_CODE = 8'h02,
    parameter logic [7:0] VOL_CODE  = 8'h91
) (
    input  logic [STEP_W-1:0] idx,
    output script_entry_t     entry
);
    logic [7:0] route_on;

    always_comb begin
        route_on = 8'h00;
        route_on[ROUTE_LINE_BIT] = 1'b1;
    end

    always_comb begin
        entry = '0;
        unique case (idx)
            4'd0:  entry = '{RG_RATE,  RATE_CODE,          1'b0, 1'b0};
            4'd1:  entry = '{RG_ROUTE, route_on,           1'b0, 1'b0};
            4'd2:  entry = '{RG_MODE,  mode_word(1'b0),    1'b0, 1'b0};
            4'd3:  entry = '{RG_LEVEL, 8'h00,              1'b0, 1'b0};
            4'd4:  entry = '{RG_VOL,   VOL_CODE,           1'b0, 1'b0};
            4'd5:  entry = '{RG_MODE,  mode_word(1'b1),    1'b0, 1'b0};
            4'd6:  entry = '{RG_POWER, power_word(1'b1),   1'b1, 1'b0};
            4'd7:  entry = '{RG_MODE,  mode_word(1'b0),    1'b0, 1'b1};
            4'd8:  entry = '{RG_MODE,  mode_word(1'b1),    1'b0, 1'b0};
            4'd9:  entry = '{RG_POWER, power_word(1'b0),   1'b0, 1'b0};
            4'd10: entry = '{RG_ROUTE, 8'h00,              1'b1, 1'b0};
            4'd11: entry = '{RG_MODE,  mode_word(1'b0),    1'b0, 1'b1};
            default: entry = '0;
        endcase
    end

endmodule

// File: rtl/lo_settle_timer.sv
module lo_settle_timer #(
    parameter int WAIT_TICKS = 310
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_TICKS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIMIT);

endmodule

// File: rtl/lo_stop_latch.sv
module lo_stop_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (clr) begin
            pend <= 1'b0;
        end else if (set) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/lineout_seq.sv
module lineout_seq
    import lineout_seq_pkg::*;
#(
    parameter int         TICK_US    = 1000,
    parameter int         WAIT_TICKS = 310000 / TICK_US,
    parameter logic [7:0] RATE_CODE  = 8'h02,
    parameter logic [7:0] VOL_CODE   = 8'h91
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic       stop_i,
    output logic       wr_valid_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    input  logic       wr_ready_i,
    output logic       busy_o,
    output logic       active_o,
    output logic       done_o
);
    localparam logic [STEP_W-1:0] STEP_UP0 = STEP_W'(UP_FIRST);
    localparam logic [STEP_W-1:0] STEP_DN0 = STEP_W'(DN_FIRST);

    seq_state_t        state, state_nx;
    logic [STEP_W-1:0] step, step_nx;
    script_entry_t     cur;
    logic              hs, expired, pend_stop, in_up, done_q;

    lo_script_rom #(
        .RATE_CODE(RATE_CODE),
        .VOL_CODE (VOL_CODE)
    ) u_rom (
        .idx  (step),
        .entry(cur)
    );

    lo_settle_timer #(
        .WAIT_TICKS(WAIT_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state != ST_SETTLE),
        .tick   (tick_i),
        .expired(expired)
    );

    assign in_up = (state == ST_ISSUE || state == ST_SETTLE) && (step < STEP_DN0);

    lo_stop_latch u_stop (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (stop_i && in_up),
        .clr  (state == ST_LIVE),
        .pend (pend_stop)
    );

    assign hs = (state == ST_ISSUE) && wr_ready_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step   <= STEP_UP0;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            step   <= step_nx;
            done_q <= hs && cur.final_step;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        step_nx  = step;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    state_nx = ST_ISSUE;
                    step_nx  = STEP_UP0;
                end
            end
            ST_ISSUE: begin
                if (hs) begin
                    if (cur.final_step) begin
                        state_nx = (step < STEP_DN0) ? ST_LIVE : ST_IDLE;
                    end else begin
                        step_nx  = step + STEP_W'(1);
                        state_nx = cur.settle_after ? ST_SETTLE : ST_ISSUE;
                    end
                end
            end
            ST_SETTLE: begin
                if (expired) begin
                    state_nx = ST_ISSUE;
                end
            end
            ST_LIVE: begin
                if (stop_i || pend_stop) begin
                    state_nx = ST_ISSUE;
                    step_nx  = STEP_DN0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_valid_o = (state == ST_ISSUE);
        wr_addr_o  = cur.addr;
        wr_data_o  = cur.data;
        busy_o     = (state == ST_ISSUE) || (state == ST_SETTLE);
        active_o   = (state == ST_LIVE);
        done_o     = done_q;
    end

endmodule

// File: rtl/lineout_seq_chk.sv
module lineout_seq_chk #(
    parameter int WAIT_TICKS = 310
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_valid_o,
    input logic [7:0] wr_addr_o,
    input logic [7:0] wr_data_o,
    input logic       wr_ready_i,
    input logic       busy_o,
    input logic       active_o,
    input logic       done_o
);
    int   ticks_since;
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_since <= 0;
            armed       <= 1'b0;
        end else if (wr_valid_o && wr_ready_i) begin
            ticks_since <= 0;
            if (wr_addr_o == 8'h00)
                armed <= 1'b1;
            else if (wr_addr_o == 8'h03 && wr_data_o == 8'h02)
                armed <= 1'b0;
        end else if (tick_i && ticks_since < WAIT_TICKS) begin
            ticks_since <= ticks_since + 1;
        end
    end

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_valid_o); // R1
    AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && armed && wr_addr_o == 8'h03 && wr_data_o == 8'h02 |-> ticks_since >= WAIT_TICKS); // R4 R7
    AST_LIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_o && busy_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5 R11
    AST_POWER_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_addr_o == 8'h00 |-> wr_data_o[2] == wr_data_o[3] && wr_data_o[3] == wr_data_o[7]); // R8
    AST_LIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> done_o); // R5

endmodule

bind lineout_seq lineout_seq_chk #(.WAIT_TICKS(WAIT_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_ready_i(wr_ready_i),
    .busy_o    (busy_o),
    .active_o  (active_o),
    .done_o    (done_o)
);

// File: tb/lineout_seq_test.sv
module lineout_seq_test;
    localparam int WT = 5;

    // {addr, data, ready delay}
    localparam logic [19:0] VEC [12] = '{
        {8'h05, 8'h02, 4'd0}, {8'h02, 8'h10, 4'd2}, {8'h03, 8'h02, 4'd1},
        {8'h07, 8'h00, 4'd0}, {8'h0A, 8'h91, 4'd3}, {8'h03, 8'h42, 4'd0},
        {8'h00, 8'hCC, 4'd1}, {8'h03, 8'h02, 4'd2},
        {8'h03, 8'h42, 4'd2}, {8'h00, 8'h40, 4'd0}, {8'h02, 8'h00, 4'd1},
        {8'h03, 8'h02, 4'd0}
    };

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic       start = 1'b0, stop = 1'b0, ready = 1'b0;
    logic       wr_valid, busy, active, done;
    logic [7:0] wr_addr, wr_data;
    int         n_chk = 0, n_bad = 0, since = 0, tdiv = 0;

    lineout_seq #(.WAIT_TICKS(WT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .stop_i(stop),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_ready_i(ready), .busy_o(busy), .active_o(active), .done_o(done)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tick = (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    always @(posedge clk) begin
        if (wr_valid && ready) since <= 0;
        else if (tick) since <= since + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic do_step(input int i);
        logic [19:0] v;
        string       req;
        int          guard;
        v   = VEC[i];
        req = (i < 8) ? "R2" : "R7";
        guard = 0;
        while (!wr_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(wr_valid, req, int'(wr_valid), 1);
        chk(wr_addr == v[19:12], req, wr_addr, v[19:12]);
        chk(wr_data == v[11:4], req, wr_data, v[11:4]);
        if (i == 7)  chk(since >= WT, "R4", since, WT);
        if (i == 11) chk(since >= WT, "R7", since, WT);
        if (i == 6 || i == 9)
            chk(wr_data[2] == wr_data[3] && wr_data[3] == wr_data[7], "R8", wr_data, v[11:4]);
        if (i >= 8) chk(!active, "R6", int'(active), 0);
        for (int k = 0; k < int'(v[3:0]); k++) begin
            @(negedge clk);
            chk(wr_valid && wr_addr == v[19:12] && wr_data == v[11:4], "R3",
                {wr_valid, wr_addr, wr_data}, {1'b1, v[19:4]});
        end
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk({wr_valid, busy, active, done} == 4'b0, "R1", {wr_valid, busy, active, done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({wr_valid, busy, active, done} == 4'b0, "R1", {wr_valid, busy, active, done}, 0);

        // stop while idle is ignored
        pulse(stop);
        for (int k = 0; k < 5; k++) begin
            chk(!wr_valid && !busy, "R10", {wr_valid, busy}, 0);
            @(negedge clk);
        end

        // full up / down walk
        pulse(start);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) pulse(start); // R10 start while busy ignored
            do_step(i);
        end
        chk(active && done && !busy, "R5", {active, done, busy}, 3'b110);
        @(negedge clk);
        chk(!done && active, "R5", {done, active}, 2'b01);

        pulse(start); // R10 start while live ignored
        for (int k = 0; k < 5; k++) begin
            chk(!wr_valid && !busy && active, "R10", {wr_valid, busy, active}, 3'b001);
            @(negedge clk);
        end

        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(wr_valid && !active, "R6", {wr_valid, active}, 2'b10);
        for (int i = 8; i < 12; i++) do_step(i);
        chk(done && !active && !busy, "R11", {done, active, busy}, 3'b100);
        @(negedge clk);
        chk(!done && !wr_valid, "R11", {done, wr_valid}, 0);

        // stop during power-up is latched
        repeat (3) @(negedge clk);
        pulse(start);
        for (int i = 0; i < 3; i++) do_step(i);
        pulse(stop);
        for (int i = 3; i < 8; i++) do_step(i);
        chk(active && done, "R9", {active, done}, 2'b11);
        @(negedge clk);
        chk(wr_valid && !active && wr_addr == 8'h03 && wr_data == 8'h42, "R9",
            {wr_valid, active, wr_addr, wr_data}, {2'b10, 8'h03, 8'h42});
        for (int i = 8; i < 12; i++) do_step(i);
        chk(done && !busy && !active, "R11", {done, busy, active}, 3'b100);
        repeat (3) @(negedge clk);
        chk(!wr_valid && !busy, "R10", {wr_valid, busy}, 0);

        summary();
        $finish;
    end

endmodule